// File: doc/BRIEF.md
# Reset Release Sequencer

This block controls how a microcontroller leaves an external reset, including a reset applied while the chip sits in a clock-stopped sleep state. While the active-low reset pin is low, everything is held: the internal reset is active, the CPU clock enable is off, no stabilization count runs, general ports float and a dedicated reset-indicator port drives low. Once the pin rises, the internal reset is released through a short synchronizer. If a crystal is the selected clock source, the block then counts an oscillation-settling interval of oscillator cycles. It then raises a configuration-load request and holds the CPU stopped until the configuration memory acknowledges or a timeout count runs out.

Normal CPU operation starts only after that phase. The ports stay floating, and the indicator port stays low, until software issues a release strobe while the CPU is running. Oscillator cycles are presented as a clock-enable pulse (`osc_tick`) on the block clock.

Top module: `rst_release_seq`

## Requirements
- R1: While `rst_pin_n` is 0, `int_rst_n`, `cpu_clk_en` and `cfg_req` are 0. This takes effect without waiting for a clock edge, from any state.
- R2: After `rst_pin_n` rises, `int_rst_n` becomes 1 after exactly SYNC_STAGES rising clock edges (default 2).
- R3: `port_hiz` is 1 and `rstout_val` is 0 from any reset onward. A `port_release` strobe clears `port_hiz` and sets `rstout_val` on the next edge only if `cpu_clk_en` is 1. A strobe at any other time has no effect.
- R4: With `clk_src` = 1 (crystal), the sequencer waits for 2^(EXP_BASE+`stab_sel`) edges at which `osc_tick` is 1. Counting starts with the edge after the one that leaves the idle state. `stab_sel` 0 gives exponent EXP_BASE and 7 gives EXP_BASE+7 (default 10..17). `cfg_req` becomes 1 at the edge that completes the count.
- R5: With `clk_src` = 0 (internal or external clock), there is no settling interval. `cfg_req` becomes 1 at edge SYNC_STAGES+1 after the pin release.
- R6: `cfg_req` stays 1 and `cpu_clk_en` stays 0 for the whole configuration phase. `cpu_clk_en` becomes 1, and `cfg_req` becomes 0, at the first edge that samples `cfg_ack` = 1 during that phase.
- R7: If no acknowledge is sampled in CFG_TMO edges of the configuration phase, the block enters run with `cfg_timeout` = 1. An acknowledge on the last of those edges wins, and `cfg_timeout` stays 0.
- R8: Once `cpu_clk_en` is 1 it stays 1 until the pin is asserted again. A new pin assertion during the settling or configuration phase restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | Asynchronous external reset, active low |
| osc_tick | input | 1 | One oscillator cycle elapsed (clock enable) |
| clk_src | input | 1 | 1 = crystal, 0 = internal oscillator or external clock |
| stab_sel | input | 3 | Settling interval select, exponent EXP_BASE+value |
| cfg_ack | input | 1 | Configuration byte loaded |
| port_release | input | 1 | Software strobe that releases the ports |
| int_rst_n | output | 1 | Internal reset, active low |
| cpu_clk_en | output | 1 | CPU clock enable |
| cfg_req | output | 1 | Configuration load request (level) |
| cfg_timeout | output | 1 | Configuration phase ended without acknowledge |
| port_hiz | output | 1 | Tri-state enable for general ports |
| rstout_val | output | 1 | Drive value of the reset-indicator port |

## Verification
The bench sweeps every settling select, with the oscillator pulse both steady and gapped, so a timer that counted block clocks instead of oscillator cycles, or decoded the select off by one, would raise the request at the wrong edge. It places the acknowledge before, on and after the last timeout edge. A wrong priority between acknowledge and timeout would either set the flag falsely or enter run one cycle late. Port release strobes are sent during the configuration phase, where a leaky gate would float the ports early. The pin is also reasserted during settling and during run, where a synchronous-only reset would leave the CPU enabled until the next edge.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_SETTLE = 2'd1,
      SEQ_CFG = 2'd2,
      SEQ_RUN = 2'd3
   } seq_state_t;
endpackage

// File: rtl/rrs_sync.sv
module rrs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic sync_n
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rrs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/rrs_settle_timer.sv
module rrs_settle_timer #(
   parameter int EXP_BASE = 10,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             active,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic             done
);
   localparam int MAX_SEL = (1 << SEL_W) - 1;
   localparam int CNT_W = EXP_BASE + MAX_SEL;

   generate
      if (EXP_BASE < 1) begin : g_bad
         $error("rrs_settle_timer: EXP_BASE must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic [SEL_W-1:0] shift;

   assign shift = SEL_W'(MAX_SEL) - sel;
   assign limit = {CNT_W{1'b1}} >> shift;
   assign done  = active && tick && (cnt == limit);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     cnt <= '0;
      else if (!active) cnt <= '0;
      else if (tick)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rrs_cfg_timer.sv
module rrs_cfg_timer #(
   parameter int TMO = 4096
) (
   input  logic clk,
   input  logic arst_n,
   input  logic active,
   output logic expire
);
   localparam int CNT_W = $clog2(TMO);

   generate
      if (TMO < 2) begin : g_bad
         $error("rrs_cfg_timer: TMO must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign expire = active && (cnt == CNT_W'(TMO - 1));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)      cnt <= '0;
      else if (!active) cnt <= '0;
      else if (!expire) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
   import rrs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int EXP_BASE = 10,
   parameter int SEL_W = 3,
   parameter int CFG_TMO = 4096,
   parameter bit XTAL_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_pin_n,
   input  logic             osc_tick,
   input  logic             clk_src,
   input  logic [SEL_W-1:0] stab_sel,
   input  logic             cfg_ack,
   input  logic             port_release,
   output logic             int_rst_n,
   output logic             cpu_clk_en,
   output logic             cfg_req,
   output logic             cfg_timeout,
   output logic             port_hiz,
   output logic             rstout_val
);
   seq_state_t state, state_nxt;
   logic       sync_n;
   logic       settle_done;
   logic       cfg_expire;
   logic       want_settle;

   rrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (rst_pin_n),
      .sync_n (sync_n)
   );

   generate
      if (XTAL_SUPPORT) begin : g_xtal
         rrs_settle_timer #(.EXP_BASE(EXP_BASE), .SEL_W(SEL_W)) u_settle (
            .clk    (clk),
            .arst_n (rst_pin_n),
            .active (state == SEQ_SETTLE),
            .tick   (osc_tick),
            .sel    (stab_sel),
            .done   (settle_done)
         );
         assign want_settle = clk_src;
      end else begin : g_noxtal
         assign settle_done = 1'b1;
         assign want_settle = 1'b0;
      end
   endgenerate

   rrs_cfg_timer #(.TMO(CFG_TMO)) u_cfg (
      .clk    (clk),
      .arst_n (rst_pin_n),
      .active (state == SEQ_CFG),
      .expire (cfg_expire)
   );

   always_comb begin
      state_nxt = state;
      unique case (state)
         SEQ_IDLE:   if (sync_n) state_nxt = want_settle ? SEQ_SETTLE : SEQ_CFG;
         SEQ_SETTLE: if (settle_done) state_nxt = SEQ_CFG;
         SEQ_CFG:    if (cfg_ack || cfg_expire) state_nxt = SEQ_RUN;
         SEQ_RUN:    state_nxt = SEQ_RUN;
         default:    state_nxt = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_pin_n) begin
      if (!rst_pin_n) begin
         state       <= SEQ_IDLE;
         cfg_timeout <= 1'b0;
         port_hiz    <= 1'b1;
         rstout_val  <= 1'b0;
      end else begin
         state <= state_nxt;
         if (state == SEQ_CFG && !cfg_ack && cfg_expire) cfg_timeout <= 1'b1;
         if (state == SEQ_RUN && port_release) begin
            port_hiz   <= 1'b0;
            rstout_val <= 1'b1;
         end
      end
   end

   assign int_rst_n  = sync_n;
   assign cpu_clk_en = (state == SEQ_RUN);
   assign cfg_req    = (state == SEQ_CFG);
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker (
   input logic clk,
   input logic rst_pin_n,
   input logic cfg_ack,
   input logic port_release,
   input logic int_rst_n,
   input logic cpu_clk_en,
   input logic cfg_req,
   input logic cfg_timeout,
   input logic port_hiz
);
   assert_pin_holds_R1: assert property (@(posedge clk)
      !rst_pin_n |-> (!int_rst_n && !cpu_clk_en && !cfg_req));

   assert_sync_release_R2: assert property (@(posedge clk) disable iff (!rst_pin_n)
      $rose(int_rst_n) |-> $past(rst_pin_n));

   assert_port_release_gate_R3: assert property (@(posedge clk) disable iff (!rst_pin_n)
      $fell(port_hiz) |-> $past(port_release && cpu_clk_en));

   assert_cfg_cpu_excl_R6: assert property (@(posedge clk)
      !(cfg_req && cpu_clk_en));

   assert_run_after_cfg_R6: assert property (@(posedge clk) disable iff (!rst_pin_n)
      $rose(cpu_clk_en) |-> $past(cfg_req));

   assert_timeout_flag_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
      $rose(cfg_timeout) |-> (cpu_clk_en && $past(cfg_req && !cfg_ack)));

   assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!rst_pin_n)
      cpu_clk_en |=> cpu_clk_en);
endmodule

bind rst_release_seq rrs_checker u_rrs_checker (
   .clk          (clk),
   .rst_pin_n    (rst_pin_n),
   .cfg_ack      (cfg_ack),
   .port_release (port_release),
   .int_rst_n    (int_rst_n),
   .cpu_clk_en   (cpu_clk_en),
   .cfg_req      (cfg_req),
   .cfg_timeout  (cfg_timeout),
   .port_hiz     (port_hiz)
);

// File: tb/rst_release_seq_test.sv
module rst_release_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC = 2;
   localparam int EXPB = 2;
   localparam int TMO = 40;
   localparam int NEVER = 100000;

   logic       clk = 1'b0;
   logic       rst_pin_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic       clk_src = 1'b0;
   logic [2:0] stab_sel = 3'd0;
   logic       cfg_ack = 1'b0;
   logic       port_release = 1'b0;
   logic       int_rst_n, cpu_clk_en, cfg_req, cfg_timeout, port_hiz, rstout_val;

   int checks = 0;
   int fails = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rst_release_seq #(
      .SYNC_STAGES(SYNC), .EXP_BASE(EXPB), .SEL_W(3), .CFG_TMO(TMO), .XTAL_SUPPORT(1'b1)
   ) uut (
      .clk(clk), .rst_pin_n(rst_pin_n), .osc_tick(osc_tick), .clk_src(clk_src),
      .stab_sel(stab_sel), .cfg_ack(cfg_ack), .port_release(port_release),
      .int_rst_n(int_rst_n), .cpu_clk_en(cpu_clk_en), .cfg_req(cfg_req),
      .cfg_timeout(cfg_timeout), .port_hiz(port_hiz), .rstout_val(rstout_val)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit tick_for(input int mode, input int n);
      return (mode == 0) ? 1'b1 : ((n % 3) != 0);
   endfunction

   // Reset from whatever state the design is in, mid high phase of the clock.
   task automatic apply_reset();
      @(posedge clk);
      #(CLK_PERIOD / 4);
      rst_pin_n = 1'b0;
      #1;
      // R1: internal reset and CPU enable drop without a clock edge
      chk(!int_rst_n && !cpu_clk_en && !cfg_req, "R1 async hold", {int_rst_n, cpu_clk_en, cfg_req}, 0);
      // R3: ports float and indicator drives low at once
      chk(port_hiz && !rstout_val, "R3 reset ports", {port_hiz, rstout_val}, 2);
      cfg_ack = 1'b1;
      osc_tick = 1'b1;
      port_release = 1'b1;
      repeat (5) @(negedge clk);
      // R1: ack, ticks and strobe during reset change nothing
      chk(!int_rst_n && !cpu_clk_en && !cfg_req && port_hiz && !rstout_val && !cfg_timeout,
          "R1 held low", {int_rst_n, cpu_clk_en, cfg_req, port_hiz, rstout_val, cfg_timeout}, 6'b000100);
      cfg_ack = 1'b0;
      port_release = 1'b0;
   endtask

   task automatic run_seq(input bit src, input int sel, input int dly, input int mode, input int abort_at);
      int n = 0;
      int tc = 0;
      int first_int = 0, first_cfg = 0, first_run = 0;
      int exp_cfg, exp_run, cfg_seen = 0;
      int pow = 1 << (EXPB + sel);
      int tmo_end;
      bit tick_cur, chk_ignore = 0, chk_rel = 0, done = 0;
      apply_reset();
      clk_src = src;
      stab_sel = 3'(sel);
      exp_cfg = src ? 0 : SYNC + 1;
      tick_cur = tick_for(mode, 1);
      osc_tick = tick_cur;
      rst_pin_n = 1'b1;
      while (!done && n < 4000) begin
         @(posedge clk);
         n++;
         if (src && n >= SYNC + 2 && exp_cfg == 0 && tick_cur) begin
            tc++;
            if (tc == pow) exp_cfg = n;
         end
         @(negedge clk);
         if (port_release) port_release = 1'b0;
         if (chk_ignore) begin
            // R3: a strobe outside run leaves ports untouched
            chk(port_hiz && !rstout_val, "R3 strobe ignored", {port_hiz, rstout_val}, 2);
            chk_ignore = 0;
         end
         if (chk_rel) begin
            chk(!port_hiz && rstout_val, "R3 strobe in run", {port_hiz, rstout_val}, 1);
            chk(cpu_clk_en, "R8 run sticky", cpu_clk_en, 1);
            done = 1;
         end
         if (int_rst_n && first_int == 0) first_int = n;
         if (cfg_req && first_cfg == 0) begin
            first_cfg = n;
            port_release = 1'b1;
            chk_ignore = 1;
         end
         if (cfg_req) begin
            cfg_seen++;
            if (cfg_seen == dly + 1) cfg_ack = 1'b1;
         end
         if (cpu_clk_en && first_run == 0) begin
            first_run = n;
            port_release = 1'b1;
            chk_rel = 1;
         end
         if (abort_at != 0 && n == abort_at) begin
            chk(!cpu_clk_en, "R8 not yet running", cpu_clk_en, 0);
            done = 1;
         end
         tick_cur = tick_for(mode, n + 1);
         osc_tick = tick_cur;
      end
      chk(first_int == SYNC, "R2 release delay", first_int, SYNC);
      if (abort_at != 0) return;
      if (src) chk(first_cfg == exp_cfg, "R4 settle length", first_cfg, exp_cfg);
      else     chk(first_cfg == exp_cfg, "R5 no settle", first_cfg, exp_cfg);
      tmo_end = (dly + 1 < TMO) ? dly + 1 : TMO;
      exp_run = exp_cfg + tmo_end;
      chk(first_run == exp_run, "R6 run entry", first_run, exp_run);
      chk(cfg_timeout == (dly >= TMO), "R7 timeout flag", cfg_timeout, int'(dly >= TMO));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 3 + 1);
      // reset state after power-up with pin low
      chk(!int_rst_n && !cpu_clk_en && port_hiz && !rstout_val, "R1 power-up",
          {int_rst_n, cpu_clk_en, port_hiz, rstout_val}, 2);
      // R5/R6/R7: direct clock, acknowledge placed around the timeout edge
      run_seq(1'b0, 0, 0, 0, 0);
      run_seq(1'b0, 0, 1, 0, 0);
      run_seq(1'b0, 0, 7, 0, 0);
      run_seq(1'b0, 0, TMO - 2, 0, 0);
      run_seq(1'b0, 0, TMO - 1, 0, 0);
      run_seq(1'b0, 0, TMO, 0, 0);
      run_seq(1'b0, 0, NEVER, 0, 0);
      // R4: every select, steady and gapped oscillator pulses
      for (int s = 0; s < 8; s++) begin
         run_seq(1'b1, s, 3, 0, 0);
         run_seq(1'b1, s, 2, 1, 0);
      end
      // R8: reassert during settling and during configuration, then a full run
      run_seq(1'b1, 7, 3, 0, 20);
      run_seq(1'b0, 0, NEVER, 0, SYNC + 10);
      run_seq(1'b1, 1, NEVER, 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule